// File: doc/BRIEF.md
# Clock Synthesizer Program Word Calculator

This block turns a requested pixel clock into the 13-bit programming word of a serially loaded frequency synthesizer. The request is either a frequency in units of 0.01 MHz or, when `period_mode` is high, a period in picoseconds. A period is first converted into a frequency by a sequential division. The block then limits the frequency to the synthesizer's legal range and selects a power-of-two post-divider by doubling the frequency until it reaches the lower edge of the oscillator band. It then computes a rounded feedback count with a second pass through the same sequential divider.

The result packs three things: the feedback count less a fixed offset, a post-divider code and a constant pair of stop bits. The word appears together with a one-cycle `done` pulse and holds until the next result. Shifting the word out to the synthesizer is done by other logic.

Top module: `sxw_calc`

## Requirements
- R1: With `period_mode` high, the working frequency is floor(100000000 / `target`). A `target` of 0 is treated as an unbounded frequency, so it gives the same result as the upper clamp.
- R2: A working frequency above 15938 is replaced by 15938 before any further step.
- R3: A working frequency below 1000 gives `word` = 0x1800. The program field and the post-divider code are both zero.
- R4: While the frequency is below 8000 it is doubled, at most three times. Zero doublings put 0x0000 in bits 10:9. One doubling (divide by 2) puts 0x0600, two doublings (divide by 4) put 0x0400, and three doublings (divide by 8) put 0x0200.
- R5: The feedback count is floor((f*46 + 716) / 1432), where f is the doubled frequency. This is f*46/1432 rounded to nearest. Bits 8:0 of `word` hold the count minus 257.
- R6: Bits 12:11 of every result word are both 1 (0x1800).
- R7: `busy` rises in the cycle after an accepted `start`. It stays high until the cycle in which `done` pulses for one cycle, and it is low in that cycle. `word` changes only in a cycle where `done` is high, and otherwise holds its value.
- R8: A `start` while `busy` is high is ignored. The running calculation completes with the request it accepted, and it gives exactly one `done`.
- R9: After reset, `busy`, `done` and `word` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| period_mode | input | 1 | 1: `target` is a period in ps; 0: a frequency in 0.01 MHz |
| target | input | VAL_W | Requested frequency or period |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when `word` is updated |
| word | output | 13 | Packed synthesizer programming word |

## Verification
The bench builds the block with the default `VAL_W` of 27. At this width the 100,000,000 numerator and any picosecond period up to 134 million fit in the divider. This brings a zero period, a period long enough to land under 10.00 MHz, and frequencies far above the clamp into reach. Directed requests sit on both sides of 1000, 2000, 4000, 8000 and 15938, so that every post-divider setting and both clamp edges are exercised. A second start issued mid-calculation confirms that the request is not taken.

// File: rtl/sxw_pkg.sv
// Shared constants and the phase type for the synthesizer word calculator.
// Assumes frequencies are expressed in 0.01 MHz units.
package sxw_pkg;
    localparam int unsigned PERIOD_NUMER = 100_000_000;
    localparam int unsigned FREQ_CEIL    = 15938;
    localparam int unsigned FREQ_FLOOR   = 1000;
    localparam int unsigned BAND_LOW     = 8000;
    localparam int unsigned REF_MULT     = 46;
    localparam int unsigned REF_CONST    = 1432;
    localparam int unsigned ROUND_ADD    = REF_CONST / 2;
    localparam int unsigned CNT_OFFSET   = 257;
    localparam int unsigned WORD_W       = 13;
    localparam logic [12:0] STOP_PAT     = 13'h1800;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAITP,
        PH_CLAMP,
        PH_SCALE,
        PH_WAITF
    } sxw_phase_e;
endpackage

// File: rtl/sxw_div_seq.sv
// Restoring unsigned divider: one quotient bit per cycle, W cycles per divide.
// Assumes go is only raised while busy is low; a zero divisor yields all ones.
module sxw_div_seq #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         valid,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r, d_r;
    logic [W:0]    r_r;
    logic [CW-1:0] cnt;
    logic [W:0]    r_sh, r_nx;
    logic          ge;

    // One restoring step: shift in next dividend bit, subtract if it fits
    always_comb begin
        r_sh = {r_r[W-1:0], q_r[W-1]};
        ge   = (r_sh >= {1'b0, d_r});
        r_nx = ge ? (r_sh - {1'b0, d_r}) : r_sh;
    end

    // Load operands on go, then iterate W steps and flag the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r   <= '0;
            d_r   <= '0;
            r_r   <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go && !busy) begin
                q_r  <= num;
                d_r  <= den;
                r_r  <= '0;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                r_r <= r_nx;
                q_r <= {q_r[W-2:0], ge};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy  <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quo = q_r;

    // R1
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);
    // R1
    valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (!busy && $past(busy)));
endmodule

// File: rtl/sxw_pack.sv
// Packs the feedback count, post-divider code and stop bits into the word.
// Assumes cnt >= 257 whenever low_range is clear.
module sxw_pack #(
    parameter int W = 27
) (
    input  logic         low_range,
    input  logic [1:0]   pdiv,
    input  logic [W-1:0] cnt,
    output logic [12:0]  word
);
    import sxw_pkg::*;

    logic [W-1:0] field_full;
    logic [12:0]  code;

    // Select divider code and offset field, then OR in the stop pattern
    always_comb begin
        field_full = cnt - W'(CNT_OFFSET);
        unique case (pdiv)
            2'd0:    code = 13'h0000;
            2'd1:    code = 13'h0600;
            2'd2:    code = 13'h0400;
            default: code = 13'h0200;
        endcase
        if (low_range)
            word = STOP_PAT;
        else
            word = STOP_PAT | code | {4'b0, field_full[8:0]};
    end
endmodule

// File: rtl/sxw_calc.sv
// Top: converts a requested clock into a packed synthesizer program word.
// Assumes VAL_W is wide enough for the 100,000,000 period numerator.
module sxw_calc #(
    parameter int VAL_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             period_mode,
    input  logic [VAL_W-1:0] target,
    output logic             busy,
    output logic             done,
    output logic [12:0]      word
);
    import sxw_pkg::*;

    sxw_phase_e       ph;
    logic [VAL_W-1:0] f_reg;
    logic [1:0]       pdiv;
    logic             low_r;
    logic             div_go, div_busy, div_valid;
    logic [VAL_W-1:0] div_num, div_den, div_quo;
    logic [12:0]      packed_w;
    logic             low_now;

    // Route divider operands for the period or the feedback divide
    always_comb begin
        div_go  = 1'b0;
        div_num = VAL_W'(PERIOD_NUMER);
        div_den = target;
        if (ph == PH_IDLE) begin
            div_go = start && period_mode;
        end else if (ph == PH_SCALE) begin
            div_go  = (f_reg >= VAL_W'(BAND_LOW));
            div_num = f_reg * VAL_W'(REF_MULT) + VAL_W'(ROUND_ADD);
            div_den = VAL_W'(REF_CONST);
        end
    end

    sxw_div_seq #(.W(VAL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .valid (div_valid),
        .quo   (div_quo)
    );

    // Decide the out-of-range case from the unclamped frequency
    assign low_now = (f_reg < VAL_W'(FREQ_FLOOR));

    sxw_pack #(.W(VAL_W)) u_pack (
        .low_range (low_r | (ph == PH_CLAMP && low_now)),
        .pdiv      (pdiv),
        .cnt       (div_quo),
        .word      (packed_w)
    );

    // Phase sequencer: convert, clamp, scale, divide, publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            f_reg <= '0;
            pdiv  <= '0;
            low_r <= 1'b0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: if (start) begin
                    low_r <= 1'b0;
                    pdiv  <= '0;
                    f_reg <= target;
                    ph    <= period_mode ? PH_WAITP : PH_CLAMP;
                end
                PH_WAITP: if (div_valid) begin
                    f_reg <= div_quo;
                    ph    <= PH_CLAMP;
                end
                PH_CLAMP: begin
                    if (f_reg > VAL_W'(FREQ_CEIL))
                        f_reg <= VAL_W'(FREQ_CEIL);
                    if (low_now) begin
                        word <= packed_w;
                        done <= 1'b1;
                        ph   <= PH_IDLE;
                    end else begin
                        ph <= PH_SCALE;
                    end
                end
                PH_SCALE: if (f_reg < VAL_W'(BAND_LOW)) begin
                    f_reg <= f_reg << 1;
                    pdiv  <= pdiv + 2'd1;
                end else begin
                    ph <= PH_WAITF;
                end
                PH_WAITF: if (div_valid) begin
                    word <= packed_w;
                    done <= 1'b1;
                    ph   <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy = (ph != PH_IDLE);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(word));
    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R6
    stop_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word[12:11] == 2'b11));
    // R2
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_SCALE && pdiv == 2'd0) |-> (f_reg <= VAL_W'(FREQ_CEIL)));
    // R4
    post_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_SCALE && pdiv == 2'd3) |-> (f_reg >= VAL_W'(BAND_LOW)));
endmodule

// File: tb/tb_sxw_calc.sv
module tb_sxw_calc;
    localparam int VAL_W = 27;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             period_mode = 1'b0;
    logic [VAL_W-1:0] target = '0;
    logic             busy, done;
    logic [12:0]      word;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sxw_calc #(.VAL_W(VAL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .period_mode(period_mode),
        .target(target), .busy(busy), .done(done), .word(word)
    );

    function automatic logic [12:0] model(input bit pm, input longint v);
        longint f;
        int pd;
        longint c;
        logic [12:0] code;
        if (pm) f = (v == 0) ? 64'd1_000_000_000 : 100_000_000 / v;   // R1
        else    f = v;
        if (f > 15938) f = 15938;                                     // R2
        if (f < 1000) return 13'h1800;                                // R3
        pd = 0;
        while (f < 8000) begin f = f * 2; pd++; end                   // R4
        c = (f * 46 + 716) / 1432;                                    // R5
        case (pd)
            0: code = 13'h0000;
            1: code = 13'h0600;
            2: code = 13'h0400;
            default: code = 13'h0200;
        endcase
        return 13'h1800 | code | 13'(c - 257);                        // R6
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_one(input string req, input bit pm, input longint v);
        int waited;
        @(negedge clk);
        period_mode = pm;
        target = VAL_W'(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 busy after start", busy, 1);
        waited = 0;
        while (!done && waited < 200) begin @(negedge clk); waited++; end
        check({req, " word"}, word, model(pm, v));
        check("R7 busy low at done", busy, 0);
        @(negedge clk);
        check("R7 done one cycle", done, 0);
        check("R7 word holds", word, model(pm, v));
    endtask

    task automatic t_reset();
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 word", word, 0);
    endtask

    task automatic t_freq();
        run_one("R2 at ceil", 0, 15938);
        run_one("R2 above ceil", 0, 15939);
        run_one("R2 far above", 0, 50000);
        run_one("R5 no divide", 0, 12000);
        run_one("R4 band edge", 0, 8000);
        run_one("R4 div2", 0, 7999);
        run_one("R4 div2 low", 0, 4000);
        run_one("R4 div4", 0, 3999);
        run_one("R4 div4 low", 0, 2000);
        run_one("R4 div8", 0, 1999);
        run_one("R3 floor", 0, 1000);
        run_one("R3 below floor", 0, 999);
        run_one("R3 zero", 0, 0);
    endtask

    task automatic t_period();
        run_one("R1 10000ps", 1, 10000);
        run_one("R1 7395ps", 1, 7395);
        run_one("R1 40000ps", 1, 40000);
        run_one("R1 100000ps", 1, 100000);
        run_one("R1 100001ps", 1, 100001);
        run_one("R1 zero period", 1, 0);
        run_one("R1 short period", 1, 1);
    endtask

    task automatic t_busy_ignore();
        int dones;
        @(negedge clk);
        period_mode = 1'b0;
        target = VAL_W'(3000);
        start = 1'b1;
        @(negedge clk);
        target = VAL_W'(15000);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        dones = 0;
        repeat (80) begin
            if (done) begin
                dones++;
                check("R8 first request kept", word, model(0, 3000));
            end
            @(negedge clk);
        end
        check("R8 single done", dones, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_freq();
        t_period();
        t_busy_ignore();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule